// File: doc/BRIEF.md
# Segment LCD Driver Command Decoder

This block sits behind a serial-bus receiver in a segment LCD driver. Each received command byte arrives with a one-cycle valid strobe. The block sorts the byte into a command class by its high-order bit pattern and updates the control registers that the rest of the driver reads. Those registers are the hardware subaddress, the bank selectors for storing and for displaying data, the blink settings, the drive mode and the display enable.

One byte can be taken every cycle, and there is no backpressure. Every register update lands on the clock edge that samples the strobe. The bank selectors exist only for the static and 1:2 drive modes. While the drive mode is 1:3 or 1:4 multiplex, a bank-select byte is accepted but changes nothing. A byte that fits no known pattern raises a one-cycle flag and leaves all state as it was.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After reset, drive_mode is 3 (1:4 multiplex), disp_en, blink_alt, blink_freq, in_bank, out_bank, subaddr and cmd_unknown are all 0.
- R2: A byte whose bits 6:3 are 1100 loads its bits 2:0 into subaddr on the edge that samples cmd_valid.
- R3: A byte whose bits 6:2 are 11110 loads bit 1 into in_bank and bit 0 into out_bank, when drive_mode is 0 (static) or 1 (1:2).
- R4: A bank-select byte leaves in_bank and out_bank unchanged while drive_mode is 2 (1:3) or 3 (1:4).
- R5: A byte whose bits 6:3 are 1110 loads bit 2 into blink_alt (0 normal, 1 alternate bank) and bits 1:0 into blink_freq (00 off).
- R6: A byte whose bits 6:5 are 10 is a mode-set: bit 3 goes to disp_en and bits 1:0 go to drive_mode, coded 0 static, 1 for 1:2, 2 for 1:3, 3 for 1:4. Bits 4 and 2 are ignored.
- R7: Bit 7 is a continuation flag and has no effect on which command is recognised or on the values loaded.
- R8: A strobed byte that matches none of the patterns leaves every register unchanged and drives cmd_unknown high for exactly the following cycle. Such bytes are 0x00 to 0x3F, 0x68 to 0x6F and 0x7C to 0x7F, with either value of bit 7.
- R9: When cmd_valid is low, no register changes and cmd_unknown is low in the next cycle.
- R10: Bytes strobed on consecutive cycles are each applied in order, one per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte, bit 7 is the continuation flag |
| subaddr | output | 3 | Hardware subaddress counter value |
| in_bank | output | 1 | Bank selected for storing incoming data |
| out_bank | output | 1 | Bank selected for display |
| blink_alt | output | 1 | Blink mode, 1 means alternate-bank blinking |
| blink_freq | output | 2 | Blink frequency code, 0 means off |
| drive_mode | output | 2 | Multiplex drive mode code |
| disp_en | output | 1 | Display enable |
| cmd_unknown | output | 1 | One-cycle pulse for an unrecognised byte |

## Verification
The assertions assume that cmd_valid and cmd_byte are free of unknowns outside reset. They also assume the byte is meaningful only in a cycle where the strobe is high, so that each property can tie a register change to exactly one sampled byte. The stimulus keeps the strobe low while reset is applied. It changes inputs only on the falling clock edge and always drives a defined byte with the strobe, including the unknown-pattern and bit-7 variants, so the assumptions hold throughout.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    localparam int BYTE_W    = 8;
    localparam int OPCODE_W  = BYTE_W - 1;
    localparam int ARG_W     = 4;
    localparam int SUBADDR_W = 3;
    localparam int FREQ_W    = 2;
    localparam int MODE_W    = 2;

    // drive mode codes
    localparam logic [MODE_W-1:0] MODE_STATIC = 2'd0;
    localparam logic [MODE_W-1:0] MODE_MUX2   = 2'd1;
    localparam logic [MODE_W-1:0] MODE_MUX3   = 2'd2;
    localparam logic [MODE_W-1:0] MODE_MUX4   = 2'd3;

    // opcode prefixes, aligned to the top of the 7-bit opcode field
    localparam logic [1:0] PFX_MODESET = 2'b10;
    localparam logic [3:0] PFX_DEVSEL  = 4'b1100;
    localparam logic [3:0] PFX_BLINK   = 4'b1110;
    localparam logic [4:0] PFX_BANK    = 5'b11110;

    typedef enum logic [2:0] {
        KIND_UNKNOWN = 3'd0,
        KIND_MODESET = 3'd1,
        KIND_DEVSEL  = 3'd2,
        KIND_BLINK   = 3'd3,
        KIND_BANK    = 3'd4
    } cmd_kind_e;

    typedef struct packed {
        logic [SUBADDR_W-1:0] subaddr;
        logic                 in_bank;
        logic                 out_bank;
        logic                 blink_alt;
        logic [FREQ_W-1:0]    blink_freq;
        logic [MODE_W-1:0]    drive_mode;
        logic                 disp_en;
        logic                 unknown;
    } ctrl_state_t;

endpackage

// File: rtl/lcd_cmd_classify.sv
module lcd_cmd_classify
    import lcd_cmd_pkg::*;
(
    input  logic [OPCODE_W-1:0] opcode,
    output cmd_kind_e           kind
);

    always_comb begin
        kind = KIND_UNKNOWN;
        if (opcode[6:5] == PFX_MODESET) begin
            kind = KIND_MODESET;
        end else if (opcode[6:3] == PFX_DEVSEL) begin
            kind = KIND_DEVSEL;
        end else if (opcode[6:3] == PFX_BLINK) begin
            kind = KIND_BLINK;
        end else if (opcode[6:2] == PFX_BANK) begin
            kind = KIND_BANK;
        end
    end

    // the four prefixes are disjoint: at most one may match any opcode
    always_comb begin
        a_prefix_disjoint_r8: assert ($countones({opcode[6:5] == PFX_MODESET,
                                                  opcode[6:3] == PFX_DEVSEL,
                                                  opcode[6:3] == PFX_BLINK,
                                                  opcode[6:2] == PFX_BANK}) <= 1);
    end

endmodule

// File: rtl/lcd_ctrl_regs.sv
module lcd_ctrl_regs
    import lcd_cmd_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = MODE_MUX4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cmd_kind_e         kind,
    input  logic [ARG_W-1:0]  arg,
    output ctrl_state_t       state
);

    localparam ctrl_state_t RESET_STATE = '{
        subaddr:    '0,
        in_bank:    1'b0,
        out_bank:   1'b0,
        blink_alt:  1'b0,
        blink_freq: '0,
        drive_mode: RESET_MODE,
        disp_en:    1'b0,
        unknown:    1'b0
    };

    ctrl_state_t st_d, st_q;
    logic        bank_locked;

    // bank selectors only exist in static and 1:2 modes
    assign bank_locked = (st_q.drive_mode == MODE_MUX3) || (st_q.drive_mode == MODE_MUX4);

    always_comb begin
        st_d         = st_q;
        st_d.unknown = 1'b0;
        if (cmd_valid) begin
            case (kind)
                KIND_MODESET: begin
                    st_d.disp_en    = arg[3];
                    st_d.drive_mode = arg[MODE_W-1:0];
                end
                KIND_DEVSEL: begin
                    st_d.subaddr = arg[SUBADDR_W-1:0];
                end
                KIND_BLINK: begin
                    st_d.blink_alt  = arg[2];
                    st_d.blink_freq = arg[FREQ_W-1:0];
                end
                KIND_BANK: begin
                    if (!bank_locked) begin
                        st_d.in_bank  = arg[1];
                        st_d.out_bank = arg[0];
                    end
                end
                default: begin
                    st_d.unknown = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(st_q.subaddr) && $stable(st_q.in_bank) &&
                        $stable(st_q.out_bank) && $stable(st_q.blink_alt) &&
                        $stable(st_q.blink_freq) && $stable(st_q.drive_mode) &&
                        $stable(st_q.disp_en) && !st_q.unknown));

    p_unknown_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && kind == KIND_UNKNOWN) |=>
            (st_q.unknown && $stable(st_q.subaddr) && $stable(st_q.in_bank) &&
             $stable(st_q.out_bank) && $stable(st_q.blink_alt) &&
             $stable(st_q.blink_freq) && $stable(st_q.drive_mode) &&
             $stable(st_q.disp_en)));

    p_bank_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && kind == KIND_BANK && st_q.drive_mode[1]) |=>
            ($stable(st_q.in_bank) && $stable(st_q.out_bank)));

    p_subaddr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && kind == KIND_DEVSEL) |=> (st_q.subaddr == $past(arg[SUBADDR_W-1:0])));

    p_blink_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && kind == KIND_BLINK) |=>
            (st_q.blink_alt == $past(arg[2]) && st_q.blink_freq == $past(arg[FREQ_W-1:0])));

    p_unknown_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && kind != KIND_UNKNOWN) |=> !st_q.unknown);

endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
    import lcd_cmd_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = MODE_MUX4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [BYTE_W-1:0]    cmd_byte,
    output logic [SUBADDR_W-1:0] subaddr,
    output logic                 in_bank,
    output logic                 out_bank,
    output logic                 blink_alt,
    output logic [FREQ_W-1:0]    blink_freq,
    output logic [MODE_W-1:0]    drive_mode,
    output logic                 disp_en,
    output logic                 cmd_unknown
);

    cmd_kind_e   kind;
    ctrl_state_t state;
    logic        unused_cont;

    // continuation flag belongs to the bus front end (R7)
    assign unused_cont = cmd_byte[BYTE_W-1];

    lcd_cmd_classify i_classify (
        .opcode (cmd_byte[OPCODE_W-1:0]),
        .kind   (kind)
    );

    lcd_ctrl_regs #(
        .RESET_MODE (RESET_MODE)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .kind      (kind),
        .arg       (cmd_byte[ARG_W-1:0]),
        .state     (state)
    );

    assign subaddr     = state.subaddr;
    assign in_bank     = state.in_bank;
    assign out_bank    = state.out_bank;
    assign blink_alt   = state.blink_alt;
    assign blink_freq  = state.blink_freq;
    assign drive_mode  = state.drive_mode;
    assign disp_en     = state.disp_en;
    assign cmd_unknown = state.unknown;

    p_reset_mode_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (drive_mode == RESET_MODE && !disp_en && blink_freq == '0 && !cmd_unknown));

endmodule

// File: tb/test_lcd_cmd_decoder.sv
module test_lcd_cmd_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [2:0] subaddr;
    logic       in_bank, out_bank, blink_alt, disp_en, cmd_unknown;
    logic [1:0] blink_freq, drive_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected state
    logic [2:0] e_sub;
    logic       e_in, e_out, e_alt, e_en, e_unk;
    logic [1:0] e_freq, e_mode;

    always #10 clk = ~clk;

    lcd_cmd_decoder i_lcd_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .subaddr(subaddr), .in_bank(in_bank), .out_bank(out_bank),
        .blink_alt(blink_alt), .blink_freq(blink_freq), .drive_mode(drive_mode),
        .disp_en(disp_en), .cmd_unknown(cmd_unknown)
    );

    task automatic model_reset();
        e_sub = 3'd0; e_in = 0; e_out = 0; e_alt = 0; e_freq = 2'd0;
        e_mode = 2'd3; e_en = 0; e_unk = 0;
    endtask

    // expectation from the requirement encodings
    task automatic model_apply(input logic v, input logic [7:0] b);
        e_unk = 0;
        if (v) begin
            if (b[6:5] == 2'b10) begin
                e_en = b[3]; e_mode = b[1:0];
            end else if (b[6:3] == 4'b1100) begin
                e_sub = b[2:0];
            end else if (b[6:3] == 4'b1110) begin
                e_alt = b[2]; e_freq = b[1:0];
            end else if (b[6:2] == 5'b11110) begin
                if (e_mode < 2) begin e_in = b[1]; e_out = b[0]; end
            end else begin
                e_unk = 1;
            end
        end
    endtask

    task automatic check_all(input string req);
        logic [11:0] act, exp;
        act = {subaddr, in_bank, out_bank, blink_alt, blink_freq, drive_mode, disp_en, cmd_unknown};
        exp = {e_sub, e_in, e_out, e_alt, e_freq, e_mode, e_en, e_unk};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, check at the next falling edge
    task automatic step(input logic v, input logic [7:0] b, input string req);
        cmd_valid = v; cmd_byte = b;
        @(negedge clk);
        model_apply(v, b);
        check_all(req);
    endtask

    task automatic send(input logic [7:0] b, input string req);
        step(1'b1, b, req);
        step(1'b0, 8'h00, req);
    endtask

    task automatic t_reset();
        model_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        check_all("R1 during reset");
        rst_n = 1;
        @(negedge clk);
        check_all("R1 after reset");
    endtask

    task automatic t_devsel();
        for (int a = 0; a < 8; a++) send(8'h60 | 8'(a), "R2 device-select");
    endtask

    task automatic t_bank_low_mux();
        send(8'h48, "R6 mode static on");
        for (int s = 0; s < 4; s++) send(8'h78 | 8'(s), "R3 bank static");
        send(8'h49, "R6 mode 1:2");
        send(8'h7A, "R3 bank 1:2");
        send(8'h79, "R3 bank 1:2");
    endtask

    task automatic t_bank_ignored();
        send(8'h4A, "R6 mode 1:3");
        send(8'h78, "R4 bank ignored 1:3");
        send(8'h7B, "R4 bank ignored 1:3");
        send(8'h4B, "R6 mode 1:4");
        send(8'h7C & 8'h7B, "R4 bank ignored 1:4");
        send(8'h7A, "R4 bank ignored 1:4");
    endtask

    task automatic t_blink();
        for (int m = 0; m < 8; m++) send(8'h70 | 8'(m), "R5 blink-select");
    endtask

    task automatic t_modeset();
        send(8'h40, "R6 mode static off");
        send(8'h5C, "R6 mode ignore bits 4 and 2");
        send(8'h43, "R6 mode 1:4 off");
    endtask

    task automatic t_bit7();
        send(8'hE5, "R7 devsel with bit7");
        send(8'hF6, "R7 blink with bit7");
        send(8'hC8, "R7 mode-set with bit7");
        send(8'hFB, "R7 bank with bit7");
        send(8'h80, "R7 unknown with bit7");
    endtask

    task automatic t_unknown();
        send(8'h00, "R8 unknown 0x00");
        send(8'h3F, "R8 unknown 0x3F");
        send(8'h6C, "R8 unknown 0x6C");
        send(8'h7E, "R8 unknown 0x7E");
        send(8'hFF, "R8 unknown 0xFF");
    endtask

    task automatic t_idle();
        step(1'b0, 8'h63, "R9 idle byte ignored");
        step(1'b0, 8'h00, "R9 idle unknown pattern ignored");
        step(1'b0, 8'h4B, "R9 idle mode byte ignored");
    endtask

    task automatic t_back_to_back();
        step(1'b1, 8'h61, "R10 b2b devsel");
        step(1'b1, 8'h00, "R10 b2b unknown");
        step(1'b1, 8'h00, "R10 b2b unknown again");
        step(1'b1, 8'h48, "R10 b2b mode static");
        step(1'b1, 8'h7B, "R10 b2b bank");
        step(1'b1, 8'h4A, "R10 b2b mode 1:3");
        step(1'b1, 8'h78, "R10 b2b bank ignored");
        step(1'b1, 8'h73, "R10 b2b blink");
        step(1'b0, 8'h00, "R10 b2b end");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_devsel();
        t_bank_low_mux();
        t_bank_ignored();
        t_blink();
        t_modeset();
        t_bit7();
        t_unknown();
        t_idle();
        t_back_to_back();
        t_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule